// File: doc/BRIEF.md
# SPI FIFO Status and DMA Request Unit

This unit holds the two word queues that sit between a memory-side port (host or DMA engine) and a serial shift engine: a transmit queue the memory side fills and the engine drains, and a receive queue the engine fills and the memory side drains. Each queue is 32 words deep and 32 bits wide. The unit reports occupancy as a free-slot count for transmit and a filled-entry count for receive, plus full and empty flags for both queues.

Misuse of either queue is recorded in four sticky error flags. These cover overflow and underflow in each direction. A summary error bit covers all four flags, and each of the five bits is cleared by writing a one to it. A one-cycle flush pulse per direction empties a queue.

For DMA operation, a 2-bit trigger code per direction selects a level of 1, 4, 8 or 16 entries. A request line rises when the queue has room for, or holds, that many words. A block counter counts the words the engine takes from the transmit queue against a programmed block size, and the transmit request is withheld once the block is complete.

Top module: `spi_fifo_dma`

## Requirements
- R1: After reset, tx_free_o reads 32, rx_fill_o reads 0, both empty flags are 1, both full flags are 0, all five error bits are 0, both request lines are 0, and blk_cnt_o is 0.
- R2: Each queue returns words in the order they were accepted. A queue accepts one push and one pop per cycle. tx_free_o and rx_fill_o follow the pushes and pops on the next cycle. The full and empty flags reflect counts of 32 and 0.
- R3: A push while the transmit queue is full is dropped and sets tx_ovf_o. An engine pop while the transmit queue is empty sets tx_unf_o. Neither operation changes the queue contents.
- R4: An engine push while the receive queue is full is dropped and sets rx_ovf_o. A memory-side pop while the receive queue is empty sets rx_unf_o.
- R5: err_o is 1 in every cycle in which any of the four error flags is 1. Once set, it stays set until it is cleared.
- R6: The clr_i bits map to flags as follows: bit 0 clears tx_ovf, bit 1 clears tx_unf, bit 2 clears rx_ovf, bit 3 clears rx_unf, and bit 4 clears err. A 1 on a bit clears that flag on the next edge. A new error event in the same cycle wins over the clear.
- R7: A flush pulse empties its queue, and the count reads empty on the next cycle. A flush takes priority over a push or pop in the same cycle; that push or pop is ignored and raises no error.
- R8: Trigger code 0 selects a level of 1 entry, 1 selects 4, 2 selects 8, and 3 selects 16. tx_req_o is 1 when all three of these hold: dma_en_i is 1, tx_free_o is at least the TX level, and blk_cnt_o is at most blk_size_i.
- R9: rx_req_o is 1 when dma_en_i is 1 and rx_fill_o is at least the RX level.
- R10: blk_cnt_o counts successful engine pops from the transmit queue while dma_en_i is 1, up to blk_size_i+1. blk_done_o is 1 when the count equals blk_size_i+1. The count clears on the edge after any cycle with dma_en_i at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_push_i | input | 1 | Memory side writes a transmit word |
| tx_wdata_i | input | 32 | Transmit word written |
| tx_pop_i | input | 1 | Engine takes a transmit word |
| tx_rdata_o | output | 32 | Head of transmit queue |
| rx_push_i | input | 1 | Engine writes a received word |
| rx_wdata_i | input | 32 | Received word written |
| rx_pop_i | input | 1 | Memory side takes a received word |
| rx_rdata_o | output | 32 | Head of receive queue |
| tx_flush_i | input | 1 | Empty transmit queue |
| rx_flush_i | input | 1 | Empty receive queue |
| clr_i | input | 5 | Write-1-to-clear strobes for the error bits |
| dma_en_i | input | 1 | Enables requests and block counting |
| tx_trig_i | input | 2 | Transmit trigger code |
| rx_trig_i | input | 2 | Receive trigger code |
| blk_size_i | input | 16 | Words in block minus one |
| tx_full_o | output | 1 | Transmit queue full |
| tx_empty_o | output | 1 | Transmit queue empty |
| rx_full_o | output | 1 | Receive queue full |
| rx_empty_o | output | 1 | Receive queue empty |
| tx_ovf_o | output | 1 | Sticky transmit overflow |
| tx_unf_o | output | 1 | Sticky transmit underflow |
| rx_ovf_o | output | 1 | Sticky receive overflow |
| rx_unf_o | output | 1 | Sticky receive underflow |
| err_o | output | 1 | Sticky summary error |
| tx_free_o | output | 6 | Free transmit slots |
| rx_fill_o | output | 6 | Filled receive entries |
| tx_req_o | output | 1 | Transmit DMA request |
| rx_req_o | output | 1 | Receive DMA request |
| blk_cnt_o | output | 17 | Words completed in block |
| blk_done_o | output | 1 | Block complete |

## Verification
The block-counter assertions assume that blk_size_i only changes while dma_en_i is 0. A smaller block size under a running count would otherwise leave the count beyond the new limit. The stimulus reprograms the block size, trigger codes and enable only inside a gap where dma_en_i is held low for one cycle. Flush and clear strobes, pushes and pops are otherwise unconstrained. The push bias shifts between phases so that both queues reach full and empty repeatedly.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;

  typedef enum logic [1:0] {
    TRIG_1  = 2'd0,
    TRIG_4  = 2'd1,
    TRIG_8  = 2'd2,
    TRIG_16 = 2'd3
  } trig_e;

  typedef struct packed {
    logic rx_unf;
    logic rx_ovf;
    logic tx_unf;
    logic tx_ovf;
  } err_vec_t;

  function automatic logic [4:0] trig_level(input logic [1:0] code);
    case (trig_e'(code))
      TRIG_1:  return 5'd1;
      TRIG_4:  return 5'd4;
      TRIG_8:  return 5'd8;
      default: return 5'd16;
    endcase
  endfunction

endpackage

// File: rtl/sfd_fifo.sv
module sfd_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 32
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         flush_i,
  input  logic                         push_i,
  input  logic [DW-1:0]                wdata_i,
  input  logic                         pop_i,
  output logic [DW-1:0]                rdata_o,
  output logic                         full_o,
  output logic                         empty_o,
  output logic [$clog2(DEPTH+1)-1:0]   count_o,
  output logic                         ovf_evt_o,
  output logic                         unf_evt_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + AW'(1);
  endfunction

  assign full_o    = (cnt == CW'(DEPTH));
  assign empty_o   = (cnt == '0);
  assign do_push   = push_i & ~full_o  & ~flush_i;
  assign do_pop    = pop_i  & ~empty_o & ~flush_i;
  assign ovf_evt_o = push_i & full_o  & ~flush_i;
  assign unf_evt_o = pop_i  & empty_o & ~flush_i;
  assign count_o   = cnt;
  assign rdata_o   = mem[rd_ptr];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else if (flush_i) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_push) wr_ptr <= ptr_inc(wr_ptr);
      if (do_pop)  rd_ptr <= ptr_inc(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wr_ptr] <= wdata_i;
  end

  // R2
  count_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= CW'(DEPTH));

  // R7
  flush_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> empty_o);

  // R3
  drop_on_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !pop_i && !flush_i) |=> full_o);

endmodule

// File: rtl/sfd_err_flags.sv
module sfd_err_flags
  import spi_fifo_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  err_vec_t ev_i,
  input  logic [4:0] clr_i,
  output err_vec_t flags_o,
  output logic     err_o
);
  err_vec_t flags_d, flags_q;
  logic     err_q;

  // set wins over clear
  assign flags_d = err_vec_t'((flags_q & ~clr_i[3:0]) | ev_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
      err_q   <= 1'b0;
    end else begin
      flags_q <= flags_d;
      err_q   <= (err_q & ~clr_i[4]) | (|flags_d);
    end
  end

  assign flags_o = flags_q;
  assign err_o   = err_q;

  // R5
  err_cover_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|flags_o) |-> err_o);

  for (genvar k = 0; k < 4; k++) begin : g_chk
    // R3
    flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ev_i[k] |=> flags_o[k]);
    // R6
    flag_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[k] && !ev_i[k]) |=> !flags_o[k]);
  end

endmodule

// File: rtl/sfd_dma_req.sv
module sfd_dma_req
  import spi_fifo_pkg::*;
#(
  parameter int CW  = 6,
  parameter int BSW = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           dma_en_i,
  input  logic [1:0]     tx_trig_i,
  input  logic [1:0]     rx_trig_i,
  input  logic [BSW-1:0] blk_size_i,
  input  logic [CW-1:0]  tx_free_i,
  input  logic [CW-1:0]  rx_fill_i,
  input  logic           word_done_i,
  output logic           tx_req_o,
  output logic           rx_req_o,
  output logic [BSW:0]   blk_cnt_o,
  output logic           blk_done_o
);
  localparam int BCW = BSW + 1;

  logic [BCW-1:0] blk_cnt_q, blk_last;
  logic           words_left;
  logic [CW-1:0]  tx_lvl, rx_lvl;

  assign blk_last   = {1'b0, blk_size_i} + BCW'(1);
  assign words_left = (blk_cnt_q <= {1'b0, blk_size_i});
  assign tx_lvl     = CW'(trig_level(tx_trig_i));
  assign rx_lvl     = CW'(trig_level(rx_trig_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      blk_cnt_q <= '0;
    else if (!dma_en_i)               blk_cnt_q <= '0;
    else if (word_done_i && words_left) blk_cnt_q <= blk_cnt_q + BCW'(1);
  end

  assign tx_req_o   = dma_en_i && (tx_free_i >= tx_lvl) && words_left;
  assign rx_req_o   = dma_en_i && (rx_fill_i >= rx_lvl);
  assign blk_cnt_o  = blk_cnt_q;
  assign blk_done_o = (blk_cnt_q == blk_last);

  // R10
  blk_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dma_en_i |=> (blk_cnt_o == '0));

  // R10
  blk_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_en_i && !word_done_i) |=> $stable(blk_cnt_o));

  // R8
  tx_req_room_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_req_o |-> (tx_free_i != '0));

endmodule

// File: rtl/spi_fifo_dma.sv
module spi_fifo_dma
  import spi_fifo_pkg::*;
#(
  parameter int DW    = 32,
  parameter int DEPTH = 32,
  parameter int BSW   = 16
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        tx_push_i,
  input  logic [DW-1:0]               tx_wdata_i,
  input  logic                        tx_pop_i,
  output logic [DW-1:0]               tx_rdata_o,
  input  logic                        rx_push_i,
  input  logic [DW-1:0]               rx_wdata_i,
  input  logic                        rx_pop_i,
  output logic [DW-1:0]               rx_rdata_o,
  input  logic                        tx_flush_i,
  input  logic                        rx_flush_i,
  input  logic [4:0]                  clr_i,
  input  logic                        dma_en_i,
  input  logic [1:0]                  tx_trig_i,
  input  logic [1:0]                  rx_trig_i,
  input  logic [BSW-1:0]              blk_size_i,
  output logic                        tx_full_o,
  output logic                        tx_empty_o,
  output logic                        rx_full_o,
  output logic                        rx_empty_o,
  output logic                        tx_ovf_o,
  output logic                        tx_unf_o,
  output logic                        rx_ovf_o,
  output logic                        rx_unf_o,
  output logic                        err_o,
  output logic [$clog2(DEPTH+1)-1:0]  tx_free_o,
  output logic [$clog2(DEPTH+1)-1:0]  rx_fill_o,
  output logic                        tx_req_o,
  output logic                        rx_req_o,
  output logic [BSW:0]                blk_cnt_o,
  output logic                        blk_done_o
);
  localparam int CW = $clog2(DEPTH+1);

  logic [CW-1:0] tx_cnt;
  logic          tx_ovf_ev, tx_unf_ev, rx_ovf_ev, rx_unf_ev;
  logic          tx_word_done;
  err_vec_t      ev, flags;

  sfd_fifo #(.DW(DW), .DEPTH(DEPTH)) u_tx_fifo (
    .clk_i, .rst_ni,
    .flush_i  (tx_flush_i),
    .push_i   (tx_push_i),
    .wdata_i  (tx_wdata_i),
    .pop_i    (tx_pop_i),
    .rdata_o  (tx_rdata_o),
    .full_o   (tx_full_o),
    .empty_o  (tx_empty_o),
    .count_o  (tx_cnt),
    .ovf_evt_o(tx_ovf_ev),
    .unf_evt_o(tx_unf_ev)
  );

  sfd_fifo #(.DW(DW), .DEPTH(DEPTH)) u_rx_fifo (
    .clk_i, .rst_ni,
    .flush_i  (rx_flush_i),
    .push_i   (rx_push_i),
    .wdata_i  (rx_wdata_i),
    .pop_i    (rx_pop_i),
    .rdata_o  (rx_rdata_o),
    .full_o   (rx_full_o),
    .empty_o  (rx_empty_o),
    .count_o  (rx_fill_o),
    .ovf_evt_o(rx_ovf_ev),
    .unf_evt_o(rx_unf_ev)
  );

  assign tx_free_o = CW'(DEPTH) - tx_cnt;

  assign ev.tx_ovf = tx_ovf_ev;
  assign ev.tx_unf = tx_unf_ev;
  assign ev.rx_ovf = rx_ovf_ev;
  assign ev.rx_unf = rx_unf_ev;

  sfd_err_flags u_err (
    .clk_i, .rst_ni,
    .ev_i   (ev),
    .clr_i  (clr_i),
    .flags_o(flags),
    .err_o  (err_o)
  );

  assign tx_ovf_o = flags.tx_ovf;
  assign tx_unf_o = flags.tx_unf;
  assign rx_ovf_o = flags.rx_ovf;
  assign rx_unf_o = flags.rx_unf;

  assign tx_word_done = tx_pop_i & ~tx_empty_o & ~tx_flush_i;

  sfd_dma_req #(.CW(CW), .BSW(BSW)) u_dma (
    .clk_i, .rst_ni,
    .dma_en_i   (dma_en_i),
    .tx_trig_i  (tx_trig_i),
    .rx_trig_i  (rx_trig_i),
    .blk_size_i (blk_size_i),
    .tx_free_i  (tx_free_o),
    .rx_fill_i  (rx_fill_o),
    .word_done_i(tx_word_done),
    .tx_req_o   (tx_req_o),
    .rx_req_o   (rx_req_o),
    .blk_cnt_o  (blk_cnt_o),
    .blk_done_o (blk_done_o)
  );

  // R3
  tx_ovf_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_push_i && tx_full_o && !tx_flush_i) |=> tx_ovf_o);

  // R4
  rx_unf_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_pop_i && rx_empty_o && !rx_flush_i) |=> rx_unf_o);

  // R9
  rx_req_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_req_o |-> !rx_empty_o);

  // R2
  free_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_empty_o |-> (tx_free_o == CW'(DEPTH)));

endmodule

// File: tb/sim_spi_fifo_dma.sv
`timescale 1ns/1ps
module sim_spi_fifo_dma;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tx_push = 0, tx_pop = 0, rx_push = 0, rx_pop = 0;
  logic [31:0] tx_wd = 0, rx_wd = 0;
  logic        tx_fl = 0, rx_fl = 0, dma_en = 0;
  logic [4:0]  clr = 0;
  logic [1:0]  tx_trig = 0, rx_trig = 0;
  logic [15:0] blk_size = 0;
  logic [31:0] tx_rd, rx_rd;
  logic        tx_full, tx_empty, rx_full, rx_empty;
  logic        tx_ovf, tx_unf, rx_ovf, rx_unf, err;
  logic [5:0]  tx_free, rx_fill;
  logic        tx_req, rx_req, blk_done;
  logic [16:0] blk_cnt;

  always #2 clk = ~clk;

  spi_fifo_dma u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .tx_push_i(tx_push), .tx_wdata_i(tx_wd), .tx_pop_i(tx_pop), .tx_rdata_o(tx_rd),
    .rx_push_i(rx_push), .rx_wdata_i(rx_wd), .rx_pop_i(rx_pop), .rx_rdata_o(rx_rd),
    .tx_flush_i(tx_fl), .rx_flush_i(rx_fl), .clr_i(clr), .dma_en_i(dma_en),
    .tx_trig_i(tx_trig), .rx_trig_i(rx_trig), .blk_size_i(blk_size),
    .tx_full_o(tx_full), .tx_empty_o(tx_empty), .rx_full_o(rx_full), .rx_empty_o(rx_empty),
    .tx_ovf_o(tx_ovf), .tx_unf_o(tx_unf), .rx_ovf_o(rx_ovf), .rx_unf_o(rx_unf), .err_o(err),
    .tx_free_o(tx_free), .rx_fill_o(rx_fill), .tx_req_o(tx_req), .rx_req_o(rx_req),
    .blk_cnt_o(blk_cnt), .blk_done_o(blk_done)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [31:0] txq[$], rxq[$];
  logic [3:0]  mflags = 0;  // {rx_unf, rx_ovf, tx_unf, tx_ovf}
  bit          merr = 0;
  int          mblk = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int lvl(input logic [1:0] c);
    return (c == 2'd0) ? 1 : (c == 2'd1) ? 4 : (c == 2'd2) ? 8 : 16;
  endfunction

  task automatic compare();
    bit exp_txr, exp_rxr;
    exp_txr = dma_en && ((32 - txq.size()) >= lvl(tx_trig)) && (mblk <= int'(blk_size));
    exp_rxr = dma_en && (rxq.size() >= lvl(rx_trig));
    chk(tx_free == 6'(32 - txq.size()), "R2 tx_free", 32'(tx_free), 32'(32 - txq.size()));
    chk(rx_fill == 6'(rxq.size()), "R2 rx_fill", 32'(rx_fill), 32'(rxq.size()));
    chk({tx_full, tx_empty, rx_full, rx_empty} ==
        {txq.size() == 32, txq.size() == 0, rxq.size() == 32, rxq.size() == 0},
        "R2 full/empty", 32'({tx_full, tx_empty, rx_full, rx_empty}),
        32'({txq.size() == 32, txq.size() == 0, rxq.size() == 32, rxq.size() == 0}));
    if (txq.size() > 0) chk(tx_rd == txq[0], "R2 tx head", tx_rd, txq[0]);
    if (rxq.size() > 0) chk(rx_rd == rxq[0], "R2 rx head", rx_rd, rxq[0]);
    chk({tx_unf, tx_ovf} == mflags[1:0], "R3 tx flags", 32'({tx_unf, tx_ovf}), 32'(mflags[1:0]));
    chk({rx_unf, rx_ovf} == mflags[3:2], "R4 rx flags", 32'({rx_unf, rx_ovf}), 32'(mflags[3:2]));
    chk(err == merr, "R5 err", 32'(err), 32'(merr));
    chk(tx_req == exp_txr, "R8 tx_req", 32'(tx_req), 32'(exp_txr));
    chk(rx_req == exp_rxr, "R9 rx_req", 32'(rx_req), 32'(exp_rxr));
    chk(blk_cnt == 17'(mblk), "R10 blk_cnt", 32'(blk_cnt), 32'(mblk));
    chk(blk_done == (mblk == int'(blk_size) + 1), "R10 blk_done", 32'(blk_done),
        32'(mblk == int'(blk_size) + 1));
  endtask

  task automatic step(input bit tp, input logic [31:0] tw, input bit tq,
                      input bit rp, input logic [31:0] rw, input bit rq,
                      input bit tf, input bit rf, input logic [4:0] cl);
    int ts, rs;
    bit t_ovf, t_unf, r_ovf, r_unf, t_pop_ok, r_pop_ok;
    tx_push = tp; tx_wd = tw; tx_pop = tq;
    rx_push = rp; rx_wd = rw; rx_pop = rq;
    tx_fl = tf; rx_fl = rf; clr = cl;
    ts = txq.size(); rs = rxq.size();
    t_ovf = tp && ts == 32 && !tf;
    t_unf = tq && ts == 0 && !tf;
    r_ovf = rp && rs == 32 && !rf;
    r_unf = rq && rs == 0 && !rf;
    t_pop_ok = tq && ts > 0 && !tf;
    r_pop_ok = rq && rs > 0 && !rf;
    if (tf) txq.delete();
    else begin
      if (t_pop_ok) void'(txq.pop_front());
      if (tp && ts < 32) txq.push_back(tw);
    end
    if (rf) rxq.delete();
    else begin
      if (r_pop_ok) void'(rxq.pop_front());
      if (rp && rs < 32) rxq.push_back(rw);
    end
    mflags = (mflags & ~cl[3:0]) | {r_unf, r_ovf, t_unf, t_ovf};
    merr = (merr && !cl[4]) || (mflags != 0);
    if (!dma_en) mblk = 0;
    else if (t_pop_ok && mblk <= int'(blk_size)) mblk++;
    @(posedge clk);
    @(negedge clk);
    compare();
    tx_push = 0; tx_pop = 0; rx_push = 0; rx_pop = 0;
    tx_fl = 0; rx_fl = 0; clr = 0;
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 0, 5'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(tx_free == 6'd32 && rx_fill == 6'd0, "R1 counts", {tx_free, rx_fill}, {6'd32, 6'd0});
    chk({tx_empty, rx_empty, tx_full, rx_full} == 4'b1100, "R1 flags",
        32'({tx_empty, rx_empty, tx_full, rx_full}), 32'hc);
    chk({tx_ovf, tx_unf, rx_ovf, rx_unf, err} == 5'b0, "R1 errors",
        32'({tx_ovf, tx_unf, rx_ovf, rx_unf, err}), 0);
    chk({tx_req, rx_req} == 2'b0 && blk_cnt == 0, "R1 dma", 32'({tx_req, rx_req}), 0);

    // R3 fill transmit queue past full
    for (int i = 0; i < 33; i++) step(1, 32'h100 + i, 0, 0, 0, 0, 0, 0, 5'd0);
    chk(tx_ovf && tx_full, "R3 overflow", 32'({tx_ovf, tx_full}), 3);
    // R6 clear tx_ovf, err remains
    step(0, 0, 0, 0, 0, 0, 0, 0, 5'b00001);
    chk(!tx_ovf && err, "R6 clear ovf", 32'({tx_ovf, err}), 1);
    step(0, 0, 0, 0, 0, 0, 0, 0, 5'b10000);
    chk(!err, "R6 clear err", 32'(err), 0);
    // R7 flush with concurrent push, no overflow raised
    step(1, 32'hdead, 0, 0, 0, 0, 1, 0, 5'd0);
    chk(tx_free == 6'd32 && !tx_ovf, "R7 flush", 32'({tx_free, tx_ovf}), 32'({6'd32, 1'b0}));
    step(0, 0, 1, 0, 0, 0, 0, 0, 5'd0);
    chk(tx_unf, "R3 underflow", 32'(tx_unf), 1);

    // R4 receive overflow, ordered drain, underflow
    for (int i = 0; i < 33; i++) step(0, 0, 0, 1, 32'h900 + i, 0, 0, 0, 5'd0);
    chk(rx_ovf, "R4 overflow", 32'(rx_ovf), 1);
    for (int i = 0; i < 33; i++) step(0, 0, 0, 0, 0, 1, 0, 0, 5'd0);
    chk(rx_unf, "R4 underflow", 32'(rx_unf), 1);
    step(0, 0, 0, 0, 0, 0, 0, 0, 5'b11111);

    // R9 receive level 8
    blk_size = 16'd100; rx_trig = 2'd2; tx_trig = 2'd3; dma_en = 1;
    for (int i = 0; i < 7; i++) step(0, 0, 0, 1, i, 0, 0, 0, 5'd0);
    chk(!rx_req, "R9 below level", 32'(rx_req), 0);
    step(0, 0, 0, 1, 7, 0, 0, 0, 5'd0);
    chk(rx_req, "R9 at level", 32'(rx_req), 1);
    // R8 transmit level 16
    for (int i = 0; i < 16; i++) step(1, i, 0, 0, 0, 0, 0, 0, 5'd0);
    chk(tx_req, "R8 free 16", 32'(tx_req), 1);
    step(1, 16, 0, 0, 0, 0, 0, 0, 5'd0);
    chk(!tx_req, "R8 free 15", 32'(tx_req), 0);

    // R10 block of three words
    dma_en = 0; step(0, 0, 0, 0, 0, 0, 1, 1, 5'd0);
    blk_size = 16'd2; tx_trig = 2'd0; dma_en = 1;
    for (int i = 0; i < 5; i++) step(1, 32'h50 + i, 0, 0, 0, 0, 0, 0, 5'd0);
    for (int i = 0; i < 4; i++) step(0, 0, 1, 0, 0, 0, 0, 0, 5'd0);
    chk(blk_done && blk_cnt == 17'd3, "R10 done", 32'(blk_cnt), 3);
    chk(!tx_req, "R8 block complete", 32'(tx_req), 0);

    // random phases
    for (int ph = 0; ph < 12; ph++) begin
      int pb;
      dma_en = 0; idle();
      blk_size = 16'($urandom_range(0, 60));
      tx_trig = 2'($urandom); rx_trig = 2'($urandom);
      dma_en = ($urandom_range(0, 5) != 0);
      pb = (ph % 3 == 0) ? 25 : (ph % 3 == 1) ? 50 : 80;
      for (int i = 0; i < 500; i++) begin
        step($urandom_range(0, 99) < pb, $urandom, $urandom_range(0, 99) < (100 - pb),
             $urandom_range(0, 99) < (100 - pb), $urandom, $urandom_range(0, 99) < pb,
             $urandom_range(0, 63) == 0, $urandom_range(0, 63) == 0,
             ($urandom_range(0, 15) == 0) ? 5'($urandom) : 5'd0);
      end
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule